// File: doc/BRIEF.md
# Power-Switch Dimming Sequencer

The block steps a lamp's dimming level using nothing but the wall switch. It watches a supply-present signal that follows the mains switch. The signal is first synchronised and filtered. The block then times every outage in clock cycles and sorts each one into two kinds when the supply returns. A brief interruption counts as a request to move to the next dimming step. A long interruption counts as an ordinary switch-off, and the lamp then comes back at full output. The logic is assumed to sit in a retained domain that keeps its clock running through brief outages.

Two strap inputs pick the step sequence. They are sampled only when the block starts afresh, which means at the first power-on after reset or after a long outage. The block outputs a two-bit level code and a percentage value for a downstream current reference. It also outputs an enable that is low whenever the filtered supply is absent.

Top module: `switch_dim_seq`

## Requirements
- R1: After reset, the first power-on gives level code 0, which is full output at 100 percent.
- R2: If the filtered supply was absent for fewer than HOLD_LIMIT cycles, the return of supply advances the level one step in the active sequence. An outage of HOLD_LIMIT-1 cycles still advances the level.
- R3: If the filtered supply was absent for HOLD_LIMIT cycles or more, the return of supply restarts at code 0. An outage of exactly HOLD_LIMIT cycles counts as long.
- R4: With both straps inactive (strap_a_gnd=0, strap_b_gnd=0), the level stays at code 0 whatever outages occur.
- R5: With only strap_b_gnd=1, the level alternates between code 0 (100 percent) and code 2 (30 percent).
- R6: With only strap_a_gnd=1, the level alternates between code 0 (100 percent) and code 1 (50 percent).
- R7: With both straps at 1, the level cycles through code 0 (100 percent), code 1 (50 percent) and code 3 (20 percent), then returns to code 0.
- R8: While the filtered supply is absent, drive_en is 0 and level_pct is 0, and level_code keeps its value.
- R9: A drop of supply_raw lasting fewer than DEB_CYCLES cycles leaves drive_en high and the level unchanged.
- R10: The straps take effect only at a power-on that follows reset or a long outage. Changing the straps before a short outage does not alter the sequence.
- R11: While drive_en is 1, level_pct is 100, 50, 30 or 20 for code 0, 1, 2 or 3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retained-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_raw | input | 1 | Unsynchronised supply-present indication from the wall switch |
| strap_a_gnd | input | 1 | First sequence strap, 1 when tied to ground |
| strap_b_gnd | input | 1 | Second sequence strap, 1 when tied to ground |
| drive_en | output | 1 | High while the filtered supply is present |
| level_code | output | 2 | Current dimming step: 0=100%, 1=50%, 2=30%, 3=20% |
| level_pct | output | PCT_W | Output percentage for the current step, 0 while off |

## Verification
The bench builds the block with SYNC_STAGES=2, DEB_CYCLES=4 and HOLD_LIMIT=64. These values make an outage of exactly the threshold, and one a single cycle shorter, only tens of cycles long. They also make a sub-filter glitch two cycles long. Under these settings every strap sequence can be walked through several full wraps, and the strap latching can be tested across both short and long outages, all well inside the run budget.

// File: rtl/dimseq_pkg.sv
package dimseq_pkg;

   // Level codes; the numeric value is what level_code carries.
   typedef enum logic [1:0] {
      LVL_FULL   = 2'd0,
      LVL_HALF   = 2'd1,
      LVL_THIRTY = 2'd2,
      LVL_FIFTH  = 2'd3
   } lvl_e;

   // Strap decode, {strap_a_gnd, strap_b_gnd}.
   typedef enum logic [1:0] {
      SEQ_NONE   = 2'b00,
      SEQ_THIRTY = 2'b01,
      SEQ_HALF   = 2'b10,
      SEQ_THREE  = 2'b11
   } seq_e;

   function automatic logic [1:0] next_step(input logic [1:0] mode, input logic [1:0] cur);
      logic [1:0] nxt;
      nxt = 2'(LVL_FULL);
      case (seq_e'(mode))
         SEQ_NONE:   nxt = 2'(LVL_FULL);
         SEQ_THIRTY: nxt = (cur == 2'(LVL_FULL)) ? 2'(LVL_THIRTY) : 2'(LVL_FULL);
         SEQ_HALF:   nxt = (cur == 2'(LVL_FULL)) ? 2'(LVL_HALF) : 2'(LVL_FULL);
         SEQ_THREE: begin
            case (lvl_e'(cur))
               LVL_FULL: nxt = 2'(LVL_HALF);
               LVL_HALF: nxt = 2'(LVL_FIFTH);
               default:  nxt = 2'(LVL_FULL);
            endcase
         end
         default:    nxt = 2'(LVL_FULL);
      endcase
      return nxt;
   endfunction

   function automatic logic [6:0] pct_of(input logic [1:0] code);
      logic [6:0] p;
      case (lvl_e'(code))
         LVL_FULL:   p = 7'd100;
         LVL_HALF:   p = 7'd50;
         LVL_THIRTY: p = 7'd30;
         default:    p = 7'd20;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sdim_debounce.sv
module sdim_debounce #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw_s;
   logic                   filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   assign raw_s = sync_q[SYNC_STAGES-1];

   generate
      if (DEB_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_q <= 1'b0;
            else        filt_q <= raw_s;
         end
      end else begin : g_count
         localparam int DW = $clog2(DEB_CYCLES);
         localparam logic [DW-1:0] LAST = DW'(DEB_CYCLES - 1);
         logic [DW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_q <= 1'b0;
               cnt_q  <= '0;
            end else if (raw_s == filt_q) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               filt_q <= raw_s;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign dout = filt_q;

endmodule

// File: rtl/sdim_outage_timer.sv
module sdim_outage_timer #(
   parameter int HOLD_LIMIT = 100_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   output logic long_gap
);

   localparam int CW = $clog2(HOLD_LIMIT + 1);
   localparam logic [CW-1:0] SAT = CW'(HOLD_LIMIT);

   logic [CW-1:0] gap_q;

   // Reset to saturation: the first power-on is handled as a long outage.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           gap_q <= SAT;
      else if (supply_ok)   gap_q <= '0;
      else if (gap_q != SAT) gap_q <= gap_q + 1'b1;
   end

   assign long_gap = (gap_q == SAT);

endmodule

// File: rtl/sdim_stepper.sv
module sdim_stepper
   import dimseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       long_gap,
   input  logic       strap_a_gnd,
   input  logic       strap_b_gnd,
   output logic       wake_evt,
   output logic [1:0] seq_mode,
   output logic [1:0] level
);

   logic       prev_q;
   logic [1:0] mode_q;
   logic [1:0] lvl_q;

   assign wake_evt = supply_ok & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         mode_q <= 2'(SEQ_NONE);
         lvl_q  <= 2'(LVL_FULL);
      end else begin
         prev_q <= supply_ok;
         if (wake_evt) begin
            if (long_gap) begin
               mode_q <= {strap_a_gnd, strap_b_gnd};
               lvl_q  <= 2'(LVL_FULL);
            end else begin
               lvl_q  <= next_step(mode_q, lvl_q);
            end
         end
      end
   end

   assign seq_mode = mode_q;
   assign level    = lvl_q;

endmodule

// File: rtl/switch_dim_seq.sv
module switch_dim_seq
   import dimseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 16,
   parameter int HOLD_LIMIT  = 100_000_000,
   parameter int PCT_W       = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_raw,
   input  logic             strap_a_gnd,
   input  logic             strap_b_gnd,
   output logic             drive_en,
   output logic [1:0]       level_code,
   output logic [PCT_W-1:0] level_pct
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DEB_CYCLES < 1) begin : g_bad_deb
         $error("DEB_CYCLES must be at least 1");
      end
      if (HOLD_LIMIT <= DEB_CYCLES) begin : g_bad_hold
         $error("HOLD_LIMIT must exceed DEB_CYCLES");
      end
      if (PCT_W < 7) begin : g_bad_pct
         $error("PCT_W must hold the value 100");
      end
   endgenerate

   logic       supply_ok;
   logic       long_gap;
   logic       wake_evt;
   logic [1:0] seq_mode;
   logic [1:0] lvl;

   sdim_debounce #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_CYCLES  (DEB_CYCLES)
   ) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (supply_raw),
      .dout  (supply_ok)
   );

   sdim_outage_timer #(
      .HOLD_LIMIT (HOLD_LIMIT)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .long_gap  (long_gap)
   );

   sdim_stepper u_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok   (supply_ok),
      .long_gap    (long_gap),
      .strap_a_gnd (strap_a_gnd),
      .strap_b_gnd (strap_b_gnd),
      .wake_evt    (wake_evt),
      .seq_mode    (seq_mode),
      .level       (lvl)
   );

   assign drive_en   = supply_ok;
   assign level_code = lvl;
   assign level_pct  = supply_ok ? PCT_W'(pct_of(lvl)) : '0;

endmodule

// File: rtl/switch_dim_seq_chk.sv
module switch_dim_seq_chk #(
   parameter int PCT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             drive_en,
   input logic [1:0]       level_code,
   input logic [PCT_W-1:0] level_pct,
   input logic             wake_evt,
   input logic             long_gap,
   input logic [1:0]       seq_mode
);

   assert_dark_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |-> level_pct == '0);

   assert_retain_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |=> $stable(level_code));

   assert_step_on_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(drive_en) |=> $stable(level_code));

   assert_long_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt && long_gap) |=> level_code == 2'd0);

   assert_strap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_evt && long_gap) |=> $stable(seq_mode));

   assert_no_dim_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seq_mode == 2'b00 |-> level_code == 2'd0);

   assert_thirty_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_mode == 2'b01 |-> level_code[0] == 1'b0);

   assert_half_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seq_mode == 2'b10 |-> level_code[1] == 1'b0);

   assert_lit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> level_pct != '0);

endmodule

bind switch_dim_seq switch_dim_seq_chk #(.PCT_W(PCT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .drive_en   (drive_en),
   .level_code (level_code),
   .level_pct  (level_pct),
   .wake_evt   (wake_evt),
   .long_gap   (long_gap),
   .seq_mode   (seq_mode)
);

// File: tb/switch_dim_seq_test.sv
module switch_dim_seq_test;

   localparam int SYNC   = 2;
   localparam int DEB    = 4;
   localparam int HOLD   = 64;
   localparam int SETTLE = SYNC + DEB + 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_raw = 1'b0;
   logic       strap_a_gnd = 1'b1;
   logic       strap_b_gnd = 1'b1;
   logic       drive_en;
   logic [1:0] level_code;
   logic [6:0] level_pct;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [1:0] cur = 2'd0;

   logic       q_en[$];
   logic [1:0] q_code[$];
   logic [6:0] q_pct[$];
   string      q_req[$];

   always #10 clk = ~clk;

   switch_dim_seq #(
      .SYNC_STAGES (SYNC),
      .DEB_CYCLES  (DEB),
      .HOLD_LIMIT  (HOLD),
      .PCT_W       (7)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_raw  (supply_raw),
      .strap_a_gnd (strap_a_gnd),
      .strap_b_gnd (strap_b_gnd),
      .drive_en    (drive_en),
      .level_code  (level_code),
      .level_pct   (level_pct)
   );

   function automatic logic [6:0] exp_pct(input logic [1:0] c);
      case (c)
         2'd0:    return 7'd100;
         2'd1:    return 7'd50;
         2'd2:    return 7'd30;
         default: return 7'd20;
      endcase
   endfunction

   // Driver side: queue an expectation; the monitor compares at the next falling edge.
   task automatic expect_now(input logic en, input logic [1:0] code, input string req);
      @(posedge clk);
      q_en.push_back(en);
      q_code.push_back(code);
      q_pct.push_back(en ? exp_pct(code) : 7'd0);
      q_req.push_back(req);
   endtask

   // Monitor: pops and compares.
   initial begin
      forever begin
         @(negedge clk);
         while (q_en.size() > 0) begin
            logic       e_en;
            logic [1:0] e_code;
            logic [6:0] e_pct;
            string      e_req;
            e_en = q_en.pop_front();
            e_code = q_code.pop_front();
            e_pct = q_pct.pop_front();
            e_req = q_req.pop_front();
            checks++;
            if (drive_en !== e_en || level_code !== e_code || level_pct !== e_pct) begin
               errors++;
               $display("FAIL %s: got en=%0b code=%0d pct=%0d, expected en=%0b code=%0d pct=%0d",
                        e_req, drive_en, level_code, level_pct, e_en, e_code, e_pct);
            end
         end
      end
   end

   task automatic outage(input int n, input logic [1:0] nxt, input string req);
      @(negedge clk);
      supply_raw = 1'b0;
      repeat (n) @(negedge clk);
      supply_raw = 1'b1;
      repeat (SETTLE) @(negedge clk);
      cur = nxt;
      expect_now(1'b1, cur, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got run still active, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R8 / R1: before any power, outputs dark and code at full
      expect_now(1'b0, 2'd0, "R8 reset dark");

      // R1: first power-on comes up at full
      @(negedge clk);
      supply_raw = 1'b1;
      repeat (SETTLE) @(negedge clk);
      expect_now(1'b1, 2'd0, "R1 first power-on");

      // R7 three-step sequence, straps both grounded
      outage(20, 2'd1, "R7 step to 50 R11");
      outage(20, 2'd3, "R7 step to 20 R11");
      outage(20, 2'd0, "R7 wrap to 100");

      // R2: one cycle below threshold is still short
      outage(HOLD - 1, 2'd1, "R2 threshold minus one");

      // R8 mid-outage, then R3 long restart
      @(negedge clk);
      supply_raw = 1'b0;
      repeat (SETTLE) @(negedge clk);
      expect_now(1'b0, cur, "R8 dark during outage, code held");
      repeat (HOLD + 10) @(negedge clk);
      supply_raw = 1'b1;
      repeat (SETTLE) @(negedge clk);
      cur = 2'd0;
      expect_now(1'b1, cur, "R3 long outage restarts");

      // R3 exact threshold is long; latch straps for the 30 sequence
      strap_a_gnd = 1'b0;
      strap_b_gnd = 1'b1;
      outage(20, 2'd1, "R10 old straps held over short");
      outage(HOLD, 2'd0, "R3 exactly threshold is long");

      // R10: change straps, then short outage uses latched mode
      strap_a_gnd = 1'b1;
      strap_b_gnd = 1'b0;
      outage(20, 2'd2, "R10 straps ignored on short R5");
      outage(20, 2'd0, "R5 back to 100");
      outage(20, 2'd2, "R5 to 30 again");

      // R6: new straps take effect on long outage
      outage(HOLD + 5, 2'd0, "R6 long restart");
      outage(20, 2'd1, "R6 step to 50");
      outage(20, 2'd0, "R6 back to 100");

      // R4: no dimming
      strap_a_gnd = 1'b0;
      strap_b_gnd = 1'b0;
      outage(HOLD + 5, 2'd0, "R4 long restart");
      outage(20, 2'd0, "R4 short stays 100");
      outage(HOLD - 1, 2'd0, "R4 second short stays 100");

      // R9: glitch shorter than the filter
      @(negedge clk);
      supply_raw = 1'b0;
      expect_now(1'b1, cur, "R9 glitch cycle 1");
      expect_now(1'b1, cur, "R9 glitch cycle 2");
      @(negedge clk);
      supply_raw = 1'b1;
      for (int i = 0; i < SETTLE; i++) expect_now(1'b1, cur, "R9 after glitch");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule